// File: doc/BRIEF.md
# Double-Data-Rate Pad Register Tile

This tile sits between a bus of chip pads and the core logic and registers all three pad paths: data coming in, data going out, and the output-enable control. Every path has two storage elements. One is clocked by a primary clock and the other by a second clock running 180 degrees out of phase. This gives one transfer per half period. On the outbound and enable paths, a half-period multiplexer forwards the primary-clock register while the primary clock is high and the secondary-clock register while it is low. On the inbound path, the two registers present the pad value sampled on each clock as two separate outputs.

All six elements of a bit share a force input, a counter-force input and a synchronous active-low initialise input. Each element has its own force level and its own initial level, both set by parameter masks. A tile-wide parameter decides whether the force inputs act synchronously or asynchronously. Each path pair has its own active-high clock enable, which should be tied high when it is not needed. Loading 1 into the primary outbound register and 0 into the secondary one forwards a copy of the clock onto the pads, with the same delay as the data. A single-rate mode uses only the primary-clock registers and bypasses the multiplexer.

Element order in both masks: bit 0 inbound rising, bit 1 inbound falling, bit 2 outbound primary, bit 3 outbound secondary, bit 4 enable primary, bit 5 enable secondary.

Top module: `ddr_io_tile`

## Requirements
- R1: While `rst_ni` is low at an element's clock edge and no force input is high, that element loads its `INIT_MASK` bit, replicated over all lanes.
- R2: `in_rise_o` captures `pad_i` on each rising edge of `clk1_i`, and `in_fall_o` captures `pad_i` on each rising edge of `clk2_i`.
- R3: In double-rate mode, `pad_o` shows the outbound primary register (loaded from `out1_i` at `clk1_i` rise) while `clk1_i` is high, and the outbound secondary register (loaded from `out2_i` at `clk2_i` rise) while `clk1_i` is low.
- R4: `pad_oe_o` is the inverse of the enable-path register selected in the same way as R3, so a registered 1 (from `ts1_i`/`ts2_i`) means high impedance.
- R5: A low `ice_i`, `oce_i` or `tce_i` makes both registers of its path hold their value across clock edges.
- R6: A high `force_i` with `unforce_i` low drives every element to its `SR_HIGH_MASK` bit at its next clock edge. This takes precedence over `rst_ni` and over the clock enables.
- R7: A high `unforce_i` with `force_i` low drives every element to the inverse of its `SR_HIGH_MASK` bit, with the same precedence as R6.
- R8: When `force_i` and `unforce_i` are high together, every element goes to 0.
- R9: With `out1_i` all ones and `out2_i` all zeros, `pad_o` is high while `clk1_i` is high and low while it is low, so it is a copy of the clock.
- R10: With `sdr_i` high, `pad_o` and `pad_oe_o` follow only the primary registers in both clock phases, and the three secondary-clock registers hold (force and initialise still apply).
- R11: With `ASYNC_SR` set, `force_i` and `unforce_i` change the elements at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1_i | input | 1 | Primary clock; its rising edges clock the primary registers and its high phase selects them |
| clk2_i | input | 1 | Secondary clock, 180 degrees from `clk1_i` |
| rst_ni | input | 1 | Synchronous active-low initialise to `INIT_MASK` |
| sdr_i | input | 1 | 1 = single-rate mode (primary registers only) |
| force_i | input | 1 | Drives elements to their `SR_HIGH_MASK` level |
| unforce_i | input | 1 | Drives elements to the opposite level |
| ice_i | input | 1 | Inbound pair clock enable, active high |
| oce_i | input | 1 | Outbound pair clock enable, active high |
| tce_i | input | 1 | Enable-path pair clock enable, active high |
| pad_i | input | WIDTH | Data arriving from the pads |
| in_rise_o | output | WIDTH | Pad sample taken at `clk1_i` rise |
| in_fall_o | output | WIDTH | Pad sample taken at `clk2_i` rise |
| out1_i | input | WIDTH | Outbound data for the primary half |
| out2_i | input | WIDTH | Outbound data for the secondary half |
| ts1_i | input | WIDTH | High-impedance request for the primary half |
| ts2_i | input | WIDTH | High-impedance request for the secondary half |
| pad_o | output | WIDTH | Multiplexed outbound pad data |
| pad_oe_o | output | WIDTH | Pad driver enable, active high |

## Verification
The register properties assume that each element sees only clean rising edges of its own clock. They also assume that `clk1_i` and `clk2_i` never rise together, and that in synchronous mode the force inputs change only between edges. The stimulus derives the secondary clock as the exact inverse of the primary clock. It changes every input half a nanosecond after a primary edge, and changes the pad value a second time half a nanosecond after the secondary edge, so no input ever moves on an active edge. The asynchronous-mode properties assume the force inputs do not pulse between two clock edges. The stimulus holds each force setting for a full period, and probes the asynchronous copy 0.2 ns after the change, well before the next edge.

// File: rtl/ddr_io_pkg.sv
`timescale 1ns/100ps
// Package ddr_io_pkg
// Shared constants and helpers for the double-rate pad register tile.
// Assumes: element indices are used as bit positions into the tile's
// per-element parameter masks.
package ddr_io_pkg;

    localparam int unsigned NUM_EL     = 6;
    localparam int unsigned EL_IN_RISE = 0;
    localparam int unsigned EL_IN_FALL = 1;
    localparam int unsigned EL_OUT_A   = 2;
    localparam int unsigned EL_OUT_B   = 3;
    localparam int unsigned EL_TS_A    = 4;
    localparam int unsigned EL_TS_B    = 5;

    // Level an element takes under the force controls; both high gives 0.
    function automatic logic force_level(input logic frc, input logic unf,
                                         input logic high_lvl);
        logic lvl;
        if (frc && unf)
            lvl = 1'b0;
        else if (frc)
            lvl = high_lvl;
        else
            lvl = ~high_lvl;
        return lvl;
    endfunction

endpackage

// File: rtl/ddr_io_cell.sv
`timescale 1ns/100ps
// Module ddr_io_cell
// One storage element (WIDTH lanes wide) of the pad tile. Priority is
// force/unforce, then initialise, then enabled load. ASYNC_SR selects
// whether the force inputs act on the clock edge or at once.
// Assumes: rst_ni is synchronous to clk_i and the force inputs do not
// pulse between clock edges in asynchronous mode.
module ddr_io_cell #(
    parameter int unsigned WIDTH    = 4,
    parameter bit          SR_HIGH  = 1'b0,
    parameter bit          INIT_VAL = 1'b0,
    parameter bit          ASYNC_SR = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_i,
    input  logic             force_i,
    input  logic             unforce_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam logic [WIDTH-1:0] INIT_VEC = {WIDTH{INIT_VAL}};
    localparam logic [WIDTH-1:0] HIGH_VEC = {WIDTH{SR_HIGH}};

    logic             forced;
    logic [WIDTH-1:0] forced_vec;
    logic [WIDTH-1:0] q_r;

    // Resolve the shared force controls into this element's level.
    always_comb begin
        forced     = force_i || unforce_i;
        forced_vec = {WIDTH{ddr_io_pkg::force_level(force_i, unforce_i, SR_HIGH)}};
    end

    generate
        if (ASYNC_SR) begin : g_async
            // Element with force inputs acting immediately.
            always_ff @(posedge clk_i or posedge force_i or posedge unforce_i) begin
                if (forced)
                    q_r <= forced_vec;
                else if (!rst_ni)
                    q_r <= INIT_VEC;
                else if (ce_i)
                    q_r <= d_i;
            end

            AST_ASYNC_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (force_i && !unforce_i) |-> (q_r == HIGH_VEC)); // R11
            AST_ASYNC_UNFORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (unforce_i && !force_i) |-> (q_r == ~HIGH_VEC)); // R11
        end else begin : g_sync
            // Element with force inputs sampled on the clock edge.
            always_ff @(posedge clk_i) begin
                if (forced)
                    q_r <= forced_vec;
                else if (!rst_ni)
                    q_r <= INIT_VEC;
                else if (ce_i)
                    q_r <= d_i;
            end

            AST_FORCE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (force_i && !unforce_i) |=> (q_r == HIGH_VEC)); // R6
            AST_UNFORCE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (unforce_i && !force_i) |=> (q_r == ~HIGH_VEC)); // R7
            AST_BOTH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (force_i && unforce_i) |=> (q_r == '0)); // R8
            AST_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!ce_i && !force_i && !unforce_i) |=> $stable(q_r)); // R5
            AST_CE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (ce_i && !force_i && !unforce_i) |=> (q_r == $past(d_i))); // R2
        end
    endgenerate

    assign q_o = q_r;

endmodule

// File: rtl/ddr_io_pair.sv
`timescale 1ns/100ps
// Module ddr_io_pair
// Two storage elements of one pad path: element A on clk_a_i, element B
// on clk_b_i. A shared enable covers both. In single-rate mode element B
// stops loading, but force and initialise still reach it.
// Assumes: clk_a_i and clk_b_i are opposite phases of one clock.
module ddr_io_pair #(
    parameter int unsigned WIDTH    = 4,
    parameter bit          SR_HIGH_A = 1'b0,
    parameter bit          SR_HIGH_B = 1'b0,
    parameter bit          INIT_A    = 1'b0,
    parameter bit          INIT_B    = 1'b0,
    parameter bit          ASYNC_SR  = 1'b0
) (
    input  logic             clk_a_i,
    input  logic             clk_b_i,
    input  logic             rst_ni,
    input  logic             sdr_i,
    input  logic             ce_i,
    input  logic             force_i,
    input  logic             unforce_i,
    input  logic [WIDTH-1:0] d_a_i,
    input  logic [WIDTH-1:0] d_b_i,
    output logic [WIDTH-1:0] q_a_o,
    output logic [WIDTH-1:0] q_b_o
);

    logic ce_b;

    // Element B loads only in double-rate mode.
    always_comb ce_b = ce_i && !sdr_i;

    ddr_io_cell #(
        .WIDTH(WIDTH), .SR_HIGH(SR_HIGH_A), .INIT_VAL(INIT_A), .ASYNC_SR(ASYNC_SR)
    ) u_elem_a (
        .clk_i(clk_a_i), .rst_ni(rst_ni), .ce_i(ce_i),
        .force_i(force_i), .unforce_i(unforce_i), .d_i(d_a_i), .q_o(q_a_o)
    );

    ddr_io_cell #(
        .WIDTH(WIDTH), .SR_HIGH(SR_HIGH_B), .INIT_VAL(INIT_B), .ASYNC_SR(ASYNC_SR)
    ) u_elem_b (
        .clk_i(clk_b_i), .rst_ni(rst_ni), .ce_i(ce_b),
        .force_i(force_i), .unforce_i(unforce_i), .d_i(d_b_i), .q_o(q_b_o)
    );

    generate
        if (!ASYNC_SR) begin : g_sdr_chk
            AST_SDR_B_HOLD: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
                (sdr_i && !force_i && !unforce_i) |=> $stable(q_b_o)); // R10
        end
    endgenerate

endmodule

// File: rtl/ddr_io_omux.sv
`timescale 1ns/100ps
// Module ddr_io_omux
// Half-period multiplexer: forwards input A while sel_i (the primary
// clock) is high and input B while it is low. In single-rate mode it
// forwards A in both phases.
// Assumes: sel_i is the primary clock itself, so the selection follows
// the clock with the same delay the registers see.
module ddr_io_omux #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             sel_i,
    input  logic             sdr_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);

    // Pick the register that owns the present half period.
    always_comb begin
        if (sdr_i || sel_i)
            y_o = a_i;
        else
            y_o = b_i;
    end

endmodule

// File: rtl/ddr_io_tile.sv
`timescale 1ns/100ps
// Module ddr_io_tile
// Pad-side register tile for WIDTH pads: an inbound pair, an outbound
// pair and an enable pair, each clocked by two opposite-phase clocks.
// The outbound and enable pairs are merged per half period. The pad
// enable is the inverse of the merged enable-path value.
// Assumes: clk2_i is clk1_i shifted by half a period. The per-element
// force and initial levels come from SR_HIGH_MASK and INIT_MASK, indexed
// by the element numbers in ddr_io_pkg.
module ddr_io_tile #(
    parameter int unsigned WIDTH = 4,
    parameter logic [ddr_io_pkg::NUM_EL-1:0] SR_HIGH_MASK = '0,
    parameter logic [ddr_io_pkg::NUM_EL-1:0] INIT_MASK    = '0,
    parameter bit ASYNC_SR = 1'b0
) (
    input  logic             clk1_i,
    input  logic             clk2_i,
    input  logic             rst_ni,
    input  logic             sdr_i,
    input  logic             force_i,
    input  logic             unforce_i,
    input  logic             ice_i,
    input  logic             oce_i,
    input  logic             tce_i,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] in_rise_o,
    output logic [WIDTH-1:0] in_fall_o,
    input  logic [WIDTH-1:0] out1_i,
    input  logic [WIDTH-1:0] out2_i,
    input  logic [WIDTH-1:0] ts1_i,
    input  logic [WIDTH-1:0] ts2_i,
    output logic [WIDTH-1:0] pad_o,
    output logic [WIDTH-1:0] pad_oe_o
);

    import ddr_io_pkg::*;

    logic [WIDTH-1:0] out_a, out_b, ts_a, ts_b, ts_sel;

    // Inbound pair: both elements sample the pad, on opposite clocks.
    ddr_io_pair #(
        .WIDTH(WIDTH),
        .SR_HIGH_A(SR_HIGH_MASK[EL_IN_RISE]), .SR_HIGH_B(SR_HIGH_MASK[EL_IN_FALL]),
        .INIT_A(INIT_MASK[EL_IN_RISE]),       .INIT_B(INIT_MASK[EL_IN_FALL]),
        .ASYNC_SR(ASYNC_SR)
    ) u_in_pair (
        .clk_a_i(clk1_i), .clk_b_i(clk2_i), .rst_ni(rst_ni), .sdr_i(sdr_i),
        .ce_i(ice_i), .force_i(force_i), .unforce_i(unforce_i),
        .d_a_i(pad_i), .d_b_i(pad_i), .q_a_o(in_rise_o), .q_b_o(in_fall_o)
    );

    // Outbound pair.
    ddr_io_pair #(
        .WIDTH(WIDTH),
        .SR_HIGH_A(SR_HIGH_MASK[EL_OUT_A]), .SR_HIGH_B(SR_HIGH_MASK[EL_OUT_B]),
        .INIT_A(INIT_MASK[EL_OUT_A]),       .INIT_B(INIT_MASK[EL_OUT_B]),
        .ASYNC_SR(ASYNC_SR)
    ) u_out_pair (
        .clk_a_i(clk1_i), .clk_b_i(clk2_i), .rst_ni(rst_ni), .sdr_i(sdr_i),
        .ce_i(oce_i), .force_i(force_i), .unforce_i(unforce_i),
        .d_a_i(out1_i), .d_b_i(out2_i), .q_a_o(out_a), .q_b_o(out_b)
    );

    // Enable-path pair.
    ddr_io_pair #(
        .WIDTH(WIDTH),
        .SR_HIGH_A(SR_HIGH_MASK[EL_TS_A]), .SR_HIGH_B(SR_HIGH_MASK[EL_TS_B]),
        .INIT_A(INIT_MASK[EL_TS_A]),       .INIT_B(INIT_MASK[EL_TS_B]),
        .ASYNC_SR(ASYNC_SR)
    ) u_ts_pair (
        .clk_a_i(clk1_i), .clk_b_i(clk2_i), .rst_ni(rst_ni), .sdr_i(sdr_i),
        .ce_i(tce_i), .force_i(force_i), .unforce_i(unforce_i),
        .d_a_i(ts1_i), .d_b_i(ts2_i), .q_a_o(ts_a), .q_b_o(ts_b)
    );

    ddr_io_omux #(.WIDTH(WIDTH)) u_out_mux (
        .sel_i(clk1_i), .sdr_i(sdr_i), .a_i(out_a), .b_i(out_b), .y_o(pad_o)
    );

    ddr_io_omux #(.WIDTH(WIDTH)) u_ts_mux (
        .sel_i(clk1_i), .sdr_i(sdr_i), .a_i(ts_a), .b_i(ts_b), .y_o(ts_sel)
    );

    // A registered 1 on the enable path requests high impedance.
    always_comb pad_oe_o = ~ts_sel;

    AST_OE_FROM_TS: assert property (@(posedge clk1_i) disable iff (!rst_ni)
        sdr_i |-> (pad_oe_o == ~ts_a)); // R4

endmodule

// File: tb/test_ddr_io_tile.sv
`timescale 1ns/100ps
module test_ddr_io_tile;

    localparam int unsigned W = 4;
    localparam logic [5:0] SRH  = 6'b101010;
    localparam logic [5:0] INIT = 6'b011001;

    logic clk1 = 1'b0;
    logic clk2;
    assign clk2 = ~clk1;
    always #2 clk1 = ~clk1;   // 250 MHz

    logic rst_n = 1'b0, sdr = 1'b0, frc = 1'b0, unf = 1'b0;
    logic ice = 1'b1, oce = 1'b1, tce = 1'b1;
    logic [W-1:0] pad_in = '0, o1 = '0, o2 = '0, t1 = '0, t2 = '0;
    logic [W-1:0] in_rise, in_fall, pad_out, pad_oe;
    logic [W-1:0] in_rise_as, in_fall_as, pad_out_as, pad_oe_as;

    ddr_io_tile #(.WIDTH(W), .SR_HIGH_MASK(SRH), .INIT_MASK(INIT), .ASYNC_SR(1'b0))
    i_ddr_io_tile (
        .clk1_i(clk1), .clk2_i(clk2), .rst_ni(rst_n), .sdr_i(sdr),
        .force_i(frc), .unforce_i(unf), .ice_i(ice), .oce_i(oce), .tce_i(tce),
        .pad_i(pad_in), .in_rise_o(in_rise), .in_fall_o(in_fall),
        .out1_i(o1), .out2_i(o2), .ts1_i(t1), .ts2_i(t2),
        .pad_o(pad_out), .pad_oe_o(pad_oe)
    );

    ddr_io_tile #(.WIDTH(W), .SR_HIGH_MASK(SRH), .INIT_MASK(INIT), .ASYNC_SR(1'b1))
    i_ddr_io_tile_as (
        .clk1_i(clk1), .clk2_i(clk2), .rst_ni(rst_n), .sdr_i(sdr),
        .force_i(frc), .unforce_i(unf), .ice_i(ice), .oce_i(oce), .tce_i(tce),
        .pad_i(pad_in), .in_rise_o(in_rise_as), .in_fall_o(in_fall_as),
        .out1_i(o1), .out2_i(o2), .ts1_i(t1), .ts2_i(t2),
        .pad_o(pad_out_as), .pad_oe_o(pad_oe_as)
    );

    typedef struct {
        int           idx;
        logic [W-1:0] pad;
        logic [W-1:0] oe;
        logic [W-1:0] inv;
        string        req;
    } item_t;

    item_t sb[$];
    int hc = 0;
    int n_chk = 0;
    int n_fail = 0;

    // Expected register contents, kept from the requirements.
    logic [W-1:0] e_ir = 'x, e_if = 'x, e_o1 = 'x, e_o2 = 'x, e_t1 = 'x, e_t2 = 'x;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic [W-1:0] d,
                                         input bit en, input int el);
        if (frc && unf)  return '0;
        if (frc)         return {W{SRH[el]}};
        if (unf)         return {W{~SRH[el]}};
        if (!rst_n)      return {W{INIT[el]}};
        if (en)          return d;
        return cur;
    endfunction

    // Monitor: compare the sample of this half period with the queue head.
    task automatic sample(input bit hi);
        item_t it;
        while (sb.size() > 0 && sb[0].idx < hc) begin
            it = sb.pop_front();
            chk(1'b0, it.req, "missed sample", '0, '0);
        end
        if (sb.size() > 0 && sb[0].idx == hc) begin
            it = sb.pop_front();
            chk(pad_out === it.pad, it.req, hi ? "pad_o high phase" : "pad_o low phase",
                pad_out, it.pad);
            chk(pad_oe === it.oe, it.req, "pad_oe_o", pad_oe, it.oe);
            if (hi)
                chk(in_rise === it.inv, it.req, "in_rise_o", in_rise, it.inv);
            else
                chk(in_fall === it.inv, it.req, "in_fall_o", in_fall, it.inv);
        end
        hc++;
    endtask

    always @(posedge clk1) begin #1; sample(1'b1); end
    always @(posedge clk2) begin #1; sample(1'b0); end

    // Driver: one period, starting 0.5 ns after a clk1 rise.
    task automatic beat(input logic [W-1:0] d1, input logic [W-1:0] d2,
                        input logic [W-1:0] s1, input logic [W-1:0] s2,
                        input logic [W-1:0] pf, input logic [W-1:0] pr,
                        input string req, input bit probe = 1'b0);
        item_t lo, hi;
        logic [W-1:0] n_if, n_o2, n_t2, n_ir, n_o1, n_t1, old_o1;
        int base = hc;
        o1 = d1; o2 = d2; t1 = s1; t2 = s2; pad_in = pf;
        old_o1 = e_o1;
        n_if = nxt(e_if, pf, ice && !sdr, 1);
        n_o2 = nxt(e_o2, d2, oce && !sdr, 3);
        n_t2 = nxt(e_t2, s2, tce && !sdr, 5);
        n_ir = nxt(e_ir, pr, ice, 0);
        n_o1 = nxt(e_o1, d1, oce, 2);
        n_t1 = nxt(e_t1, s1, tce, 4);
        lo.idx = base + 1; lo.req = req;
        lo.pad = sdr ? e_o1 : n_o2;
        lo.oe  = ~(sdr ? e_t1 : n_t2);
        lo.inv = n_if;
        hi.idx = base + 2; hi.req = req;
        hi.pad = n_o1; hi.oe = ~n_t1; hi.inv = n_ir;
        sb.push_back(lo);
        sb.push_back(hi);
        e_if = n_if; e_o2 = n_o2; e_t2 = n_t2; e_ir = n_ir; e_o1 = n_o1; e_t1 = n_t1;
        if (probe) begin
            #0.2;
            // R11: asynchronous copy changes before any edge; R6: synchronous copy waits.
            chk(pad_out_as === {W{ddr_io_pkg::force_level(frc, unf, SRH[2])}}, "R11",
                "async pad_o", pad_out_as, {W{ddr_io_pkg::force_level(frc, unf, SRH[2])}});
            chk(in_rise_as === {W{ddr_io_pkg::force_level(frc, unf, SRH[0])}}, "R11",
                "async in_rise_o", in_rise_as, {W{ddr_io_pkg::force_level(frc, unf, SRH[0])}});
            chk(pad_out === old_o1, "R6", "sync pad_o before edge", pad_out, old_o1);
            #1.8;
        end else begin
            #2;
        end
        pad_in = pr;
        #2;
    endtask

    initial begin : watchdog
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        @(posedge clk1);
        #0.5;
        // R1: initialise levels, data ignored
        beat(4'hf, 4'h0, 4'h0, 4'hf, 4'hf, 4'h0, "R1");
        beat(4'h5, 4'ha, 4'h3, 4'hc, 4'h6, 4'h9, "R1");
        beat(4'hf, 4'h0, 4'h0, 4'hf, 4'hf, 4'h0, "R1");
        rst_n = 1'b1;
        // R2 R3 R4: double-rate patterns
        beat(4'ha, 4'h5, 4'h0, 4'hf, 4'h3, 4'hc, "R2 R3 R4");
        beat(4'h6, 4'h9, 4'hf, 4'h0, 4'h9, 4'h6, "R2 R3 R4");
        beat(4'h1, 4'h8, 4'h3, 4'hc, 4'he, 4'h7, "R2 R3 R4");
        beat(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R2 R3 R4");
        // R9: clock copy on the pads
        beat(4'hf, 4'h0, 4'h0, 4'h0, 4'h5, 4'ha, "R9");
        beat(4'hf, 4'h0, 4'h0, 4'h0, 4'ha, 4'h5, "R9");
        // R5: each enable low in turn
        oce = 1'b0;
        beat(4'h0, 4'hf, 4'hf, 4'hf, 4'h3, 4'h3, "R5 oce");
        oce = 1'b1; ice = 1'b0;
        beat(4'h2, 4'h4, 4'hf, 4'hf, 4'hc, 4'hc, "R5 ice");
        ice = 1'b1; tce = 1'b0;
        beat(4'hf, 4'hf, 4'h0, 4'h0, 4'hf, 4'hf, "R5 tce");
        tce = 1'b1;
        beat(4'hf, 4'h0, 4'h0, 4'hf, 4'h0, 4'hf, "R3 setup");
        // R6 R11: force, probed between edges
        frc = 1'b1;
        beat(4'hf, 4'h0, 4'hf, 4'h0, 4'hf, 4'hf, "R6", 1'b1);
        rst_n = 1'b0; oce = 1'b0;
        beat(4'h5, 4'ha, 4'h5, 4'ha, 4'h5, 4'ha, "R6 priority");
        rst_n = 1'b1; oce = 1'b1;
        // R7 R11: counter-force
        frc = 1'b0; unf = 1'b1;
        beat(4'h0, 4'hf, 4'h0, 4'hf, 4'h0, 4'h0, "R7", 1'b1);
        // R8: both together
        frc = 1'b1;
        beat(4'hf, 4'hf, 4'hf, 4'hf, 4'hf, 4'hf, "R8");
        frc = 1'b0; unf = 1'b0;
        beat(4'h3, 4'hc, 4'h0, 4'hf, 4'h9, 4'h6, "R3 R4");
        // R10: single-rate mode
        sdr = 1'b1;
        beat(4'h7, 4'h8, 4'h5, 4'ha, 4'hf, 4'h1, "R10");
        beat(4'hb, 4'h4, 4'ha, 4'h5, 4'h0, 4'he, "R10");
        sdr = 1'b0;
        beat(4'h9, 4'h6, 4'hc, 4'h3, 4'h5, 4'ha, "R2 R3 R4");
        repeat (3) @(posedge clk1);
        #1.5;
        chk(sb.size() == 0, "R3", "scoreboard drained", W'(sb.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule